// File: doc/BRIEF.md
# I2C Register-Access Slave

This block lets an external I2C master read and write a small on-chip register space. SCL and SDA are sampled with the system clock. The block recognises START, repeated START and STOP conditions and matches its 7-bit device address. The first byte of a write transfer is a command byte that loads an internal address pointer. The bytes after it are written to consecutive locations. To read, the master issues a repeated START after the command byte, sends the address again with the read bit set, and the block then shifts out the contents of consecutive locations.

The register space itself lives outside the block. The block reaches it through a simple parallel port. A one-cycle write strobe carries the address and data. A one-cycle read request expects the read data to be valid in that same cycle.

SDA is open-drain. The block only ever pulls the line low, through an output enable. The block never stretches the clock.

Top module: `i2c_regslave`

## Requirements
- R1: After reset, `sda_oe`, `reg_wr` and `reg_rd` are all low, and the block waits for a START.
- R2: The address byte, MSB first, is `1,0,1,0,0,strap_a0,X,RnW`. Bit 1 is a don't-care. On a match the block pulls SDA low (`sda_oe`=1) through the 9th SCL high phase.
- R3: An address byte that differs in a fixed bit, or in the `strap_a0` bit, is not acknowledged. The block then ignores the bus, with no strobes and no SDA drive, until the next START or STOP.
- R4: The command byte is not acknowledged when `boot_busy` is high, when `nvm_busy` is high, or when its value exceeds LAST_ADDR (default 0x3F). The data bytes that follow it are ignored.
- R5: Each data byte of a write transfer is acknowledged and produces one single-cycle `reg_wr`, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. The pointer then advances by one, and wraps from LAST_ADDR to 0.
- R6: After a repeated START and a read address, the block issues a single-cycle `reg_rd` before each byte. It captures `reg_rdata` in that cycle and shifts it out MSB first. The pointer advances after each byte.
- R7: A master ACK (SDA low on the 9th clock) continues a read. A master NACK ends it: no further `reg_rd`, and SDA stays released until the next START or STOP.
- R8: A STOP at any bit position, including mid-byte, returns the block to idle. A partly received byte produces no write. A byte sent without a new START is not acknowledged.
- R9: A STOP in the same SCL-high interval as the preceding START is ignored, and address reception continues.
- R10: A pulse of one system-clock cycle on SCL or SDA has no effect on the transfer.
- R11: `sda_oe` only changes while the filtered SCL is low.
- R12: A transfer may carry several write sequences separated by repeated STARTs. Each sequence starts with its own command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High to pull SDA low |
| strap_a0 | input | 1 | Pin-strapped address bit |
| boot_busy | input | 1 | Reboot in progress; command byte is refused |
| nvm_busy | input | 1 | Non-volatile write in progress; command byte is refused |
| reg_addr | output | 8 | Register address for the current access |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rd | output | 1 | One-cycle read request |
| reg_rdata | input | 8 | Read data, valid while `reg_rd` is high |

## Verification
The assertions check several properties on every cycle:
- SDA is driven or released only while SCL is low.
- Every strobe lasts exactly one cycle.
- Writes never reach an address beyond LAST_ADDR.
- A START always leads to address reception, and a STOP to idle.
- The ignore state stays silent.

Other behaviours only the bench scenarios can show:
- address matching on the strap bit and the don't-care bit;
- the three refusal causes for the command byte;
- pointer wrap and byte order;
- the end of a read on a master NACK;
- STOP handling mid-byte and in the same high interval as a START;
- rejection of one-cycle glitches.

// File: rtl/i2c_regslave_pkg.sv
package i2c_regslave_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_CMD,
    PH_WDATA,
    PH_RDATA,
    PH_SKIP
  } phase_t;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] filt_o
);
  logic [W-1:0] meta_q, sync_q, hold_q, filt_q, filt_d;

  // a level is accepted only after two equal synchronized samples
  for (genvar g = 0; g < W; g++) begin : g_bit
    always_comb begin
      filt_d[g] = filt_q[g];
      if (sync_q[g] == hold_q[g]) filt_d[g] = sync_q[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      sync_q <= '1;
      hold_q <= '1;
      filt_q <= '1;
    end else begin
      meta_q <= raw_i;
      sync_q <= meta_q;
      hold_q <= sync_q;
      filt_q <= filt_d;
    end
  end

  assign filt_o = filt_q;
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q, start_hi_q, start_hi_d;
  logic stop_raw;

  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign start_o  = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_raw = scl_f & scl_q & ~sda_q & sda_f;
  assign stop_o   = stop_raw & ~start_hi_q;

  // remembers a START until the end of its SCL high interval
  always_comb begin
    start_hi_d = start_hi_q;
    if (start_o)       start_hi_d = 1'b1;
    else if (scl_fall) start_hi_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q      <= 1'b1;
      sda_q      <= 1'b1;
      start_hi_q <= 1'b0;
    end else begin
      scl_q      <= scl_f;
      sda_q      <= sda_f;
      start_hi_q <= start_hi_d;
    end
  end
endmodule

// File: rtl/i2c_slave_ctrl.sv
module i2c_slave_ctrl
  import i2c_regslave_pkg::*;
#(
  parameter int          LAST_ADDR = 63,
  parameter logic [4:0]  DEV_ID    = 5'b10100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_f,
  input  logic              sda_f,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              strap_a0,
  input  logic              boot_busy,
  input  logic              nvm_busy,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] reg_addr,
  output logic              reg_wr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_rd
);
  localparam logic [BYTE_W-1:0] LAST_B   = BYTE_W'(LAST_ADDR);
  localparam logic [3:0]        BITS_END = 4'(BYTE_W);

  phase_t            phase_q, phase_d;
  logic [3:0]        bitcnt_q, bitcnt_d;
  logic              ackph_q, ackph_d, ok_q, ok_d, rnw_q, rnw_d, mack_q, mack_d;
  logic              oe_q, oe_d, wr_q, wr_d, rd_q, rd_d;
  logic [BYTE_W-1:0] sh_q, sh_d, ptr_q, ptr_d, wd_q, wd_d, ptr_nx;
  logic              addr_hit, cmd_ok, rx_phase;

  assign addr_hit = (sh_q[7:3] == DEV_ID) && (sh_q[2] == strap_a0);
  assign cmd_ok   = !boot_busy && !nvm_busy && (sh_q <= LAST_B);
  assign ptr_nx   = (ptr_q == LAST_B) ? '0 : ptr_q + 1'b1;
  assign rx_phase = (phase_q == PH_ADDR) || (phase_q == PH_CMD) || (phase_q == PH_WDATA);

  always_comb begin
    phase_d = phase_q; bitcnt_d = bitcnt_q; ackph_d = ackph_q; ok_d = ok_q;
    rnw_d = rnw_q; mack_d = mack_q; oe_d = oe_q; sh_d = sh_q; ptr_d = ptr_q;
    wd_d = wd_q; wr_d = 1'b0; rd_d = 1'b0;
    if (start_i) begin
      phase_d = PH_ADDR; bitcnt_d = '0; ackph_d = 1'b0; oe_d = 1'b0;
    end else if (stop_i) begin
      phase_d = PH_IDLE; bitcnt_d = '0; ackph_d = 1'b0; oe_d = 1'b0;
    end else if (rd_q) begin
      sh_d = reg_rdata;
      oe_d = ~reg_rdata[BYTE_W-1];
    end else if (rx_phase) begin
      if (scl_rise && !ackph_q && bitcnt_q < BITS_END) begin
        sh_d     = {sh_q[BYTE_W-2:0], sda_f};
        bitcnt_d = bitcnt_q + 1'b1;
      end else if (scl_fall && !ackph_q && bitcnt_q == BITS_END) begin
        ackph_d = 1'b1;
        unique case (phase_q)
          PH_ADDR: begin ok_d = addr_hit; rnw_d = sh_q[0]; end
          PH_CMD: begin
            ok_d = cmd_ok;
            if (cmd_ok) ptr_d = sh_q;
          end
          default: begin ok_d = 1'b1; wr_d = 1'b1; wd_d = sh_q; end
        endcase
        oe_d = ok_d;
      end else if (scl_fall && ackph_q) begin
        ackph_d = 1'b0; bitcnt_d = '0; oe_d = 1'b0;
        if (!ok_q) phase_d = PH_SKIP;
        else begin
          unique case (phase_q)
            PH_ADDR: begin
              if (rnw_q) begin phase_d = PH_RDATA; rd_d = 1'b1; end
              else phase_d = PH_CMD;
            end
            PH_CMD:  phase_d = PH_WDATA;
            default: ptr_d = ptr_nx;
          endcase
        end
      end
    end else if (phase_q == PH_RDATA) begin
      if (scl_rise && !ackph_q && bitcnt_q < BITS_END) begin
        bitcnt_d = bitcnt_q + 1'b1;
      end else if (scl_rise && ackph_q) begin
        mack_d = ~sda_f;
      end else if (scl_fall && !ackph_q && bitcnt_q == BITS_END) begin
        ackph_d = 1'b1; oe_d = 1'b0; ptr_d = ptr_nx;
      end else if (scl_fall && !ackph_q && bitcnt_q != '0) begin
        sh_d = {sh_q[BYTE_W-2:0], 1'b0};
        oe_d = ~sh_q[BYTE_W-2];
      end else if (scl_fall && ackph_q) begin
        ackph_d = 1'b0; bitcnt_d = '0;
        if (mack_q) rd_d = 1'b1;
        else phase_d = PH_SKIP;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE; bitcnt_q <= '0; ackph_q <= 1'b0; ok_q <= 1'b0;
      rnw_q <= 1'b0; mack_q <= 1'b0; oe_q <= 1'b0; sh_q <= '0; ptr_q <= '0;
      wd_q <= '0; wr_q <= 1'b0; rd_q <= 1'b0;
    end else begin
      phase_q <= phase_d; bitcnt_q <= bitcnt_d; ackph_q <= ackph_d; ok_q <= ok_d;
      rnw_q <= rnw_d; mack_q <= mack_d; oe_q <= oe_d; sh_q <= sh_d; ptr_q <= ptr_d;
      wd_q <= wd_d; wr_q <= wr_d; rd_q <= rd_d;
    end
  end

  assign sda_oe    = oe_q;
  assign reg_addr  = ptr_q;
  assign reg_wr    = wr_q;
  assign reg_wdata = wd_q;
  assign reg_rd    = rd_q;

  // R11: the data line only moves while the clock line is low
  assert_sda_moves_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(oe_q) |-> !scl_f);
  // R5: write strobes are single cycle and stay in the legal range
  assert_wr_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);
  assert_wr_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> (reg_addr <= LAST_B));
  // R6: read requests are single cycle
  assert_rd_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);
  // R2: a START always restarts address reception
  assert_start_to_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (phase_q == PH_ADDR));
  // R8: an accepted STOP returns to idle with the line released
  assert_stop_to_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (phase_q == PH_IDLE && !oe_q));
  // R3: the ignore state issues no register access
  assert_skip_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SKIP) |-> (!reg_wr && !reg_rd));
endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave
  import i2c_regslave_pkg::*;
#(
  parameter int         LAST_ADDR = 63,
  parameter logic [4:0] DEV_ID    = 5'b10100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              strap_a0,
  input  logic              boot_busy,
  input  logic              nvm_busy,
  output logic [BYTE_W-1:0] reg_addr,
  output logic              reg_wr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_rd,
  input  logic [BYTE_W-1:0] reg_rdata
);
  localparam int LINES = 2;

  logic [LINES-1:0] filt;
  logic scl_rise, scl_fall, start_ev, stop_ev;

  i2c_line_filter #(.W(LINES)) u_filter (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  ({scl_i, sda_i}),
    .filt_o (filt)
  );

  i2c_bus_events u_events (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (filt[1]),
    .sda_f    (filt[0]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_o  (start_ev),
    .stop_o   (stop_ev)
  );

  i2c_slave_ctrl #(.LAST_ADDR(LAST_ADDR), .DEV_ID(DEV_ID)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_f     (filt[1]),
    .sda_f     (filt[0]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_i   (start_ev),
    .stop_i    (stop_ev),
    .strap_a0  (strap_a0),
    .boot_busy (boot_busy),
    .nvm_busy  (nvm_busy),
    .reg_rdata (reg_rdata),
    .sda_oe    (sda_oe),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rd    (reg_rd)
  );
endmodule

// File: tb/i2c_regslave_bench.sv
module i2c_regslave_bench;
  localparam int Q    = 8;
  localparam int LAST = 63;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic strap_a0 = 1'b0, boot_busy = 1'b0, nvm_busy = 1'b0;
  logic sda_oe, reg_wr, reg_rd;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic sda_line;

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic [7:0] buf_d [8];
  logic [7:0] buf_r [8];
  int wr_cnt = 0, rd_cnt = 0;
  int checks = 0, errors = 0;
  int gmode = 0;

  always #5 clk = ~clk;

  assign sda_line  = sda_m & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  i2c_regslave u_i2c_regslave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_a0(strap_a0), .boot_busy(boot_busy), .nvm_busy(nvm_busy),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  always @(posedge clk) begin
    if (reg_wr) begin mem[reg_addr] <= reg_wdata; wr_cnt <= wr_cnt + 1; end
    if (reg_rd) rd_cnt <= rd_cnt + 1;
  end

  function automatic logic [7:0] addr_byte(input logic a0, input logic x, input logic rnw);
    return {5'b10100, a0, x, rnw};
  endfunction

  function automatic logic [7:0] ptr_next(input logic [7:0] p);
    return (p == 8'(LAST)) ? 8'h00 : p + 8'h01;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic b_start;
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic b_stop;
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bit(input logic v);
    sda_m = v; tick(Q); scl_m = 1'b1; tick(Q);
    if (gmode == 1) begin scl_m = 1'b0; tick(1); scl_m = 1'b1; tick(Q - 1); end
    else if (gmode == 2 && v) begin sda_m = 1'b0; tick(1); sda_m = 1'b1; tick(Q - 1); end
    else tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    ack = sda_oe;
    tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1'b1; tick(Q); b[i] = sda_line; tick(Q); scl_m = 1'b0;
    end
    tick(Q); sda_m = ~mack; tick(Q); scl_m = 1'b1; tick(2 * Q);
    scl_m = 1'b0; tick(Q); sda_m = 1'b1;
  endtask

  task automatic do_write(input logic x, input logic [7:0] cmd, input int n, output logic all_ack);
    logic a;
    logic [7:0] p;
    b_start;
    send_byte(addr_byte(strap_a0, x, 1'b0), a); all_ack = a;
    send_byte(cmd, a); all_ack &= a;
    p = cmd;
    for (int k = 0; k < n; k++) begin
      send_byte(buf_d[k], a); all_ack &= a;
      exp_mem[p] = buf_d[k]; p = ptr_next(p);
    end
    b_stop;
  endtask

  task automatic do_read(input logic [7:0] cmd, input int n, input logic extra, output logic all_ack);
    logic a;
    logic [7:0] junk;
    b_start;
    send_byte(addr_byte(strap_a0, 1'b0, 1'b0), a); all_ack = a;
    send_byte(cmd, a); all_ack &= a;
    b_start;
    send_byte(addr_byte(strap_a0, 1'b0, 1'b1), a); all_ack &= a;
    for (int k = 0; k < n; k++) recv_byte(k < n - 1, buf_r[k]);
    if (extra) begin
      recv_byte(1'b0, junk);
      chk("R7 line released after master NACK", junk, 8'hFF);
    end
    b_stop;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic ok, a;
    int w0, r0;
    logic [7:0] c;
    int n;
    void'($urandom(32'h5A17));
    for (int i = 0; i < 256; i++) begin mem[i] = 8'(i * 7 + 3); exp_mem[i] = 8'(i * 7 + 3); end
    tick(4); rst_n = 1'b1; tick(4);

    // R1 reset state
    chk("R1 outputs idle after reset", {sda_oe, reg_wr, reg_rd}, 0);

    // R2 address match, don't-care bit set
    buf_d[0] = 8'hA5; buf_d[1] = 8'h3C;
    do_write(1'b1, 8'h05, 2, ok);
    chk("R2 acks with X=1", ok, 1);
    chk("R2 R5 write byte0", mem[5], 8'hA5);
    chk("R5 write byte1", mem[6], 8'h3C);
    strap_a0 = 1'b1;
    buf_d[0] = 8'h71;
    do_write(1'b0, 8'h07, 1, ok);
    chk("R2 acks with strap_a0=1", ok, 1);
    chk("R2 write with strap_a0=1", mem[7], 8'h71);

    // R3 mismatching address, strap bit and fixed bits
    w0 = wr_cnt;
    b_start; send_byte(addr_byte(1'b0, 1'b0, 1'b0), a);
    chk("R3 strap mismatch nack", a, 0);
    send_byte(8'h01, a); send_byte(8'h55, a);
    chk("R3 no ack on ignored byte", a, 0);
    b_stop;
    b_start; send_byte(8'hB4, a);
    chk("R3 fixed bit mismatch nack", a, 0);
    send_byte(8'h02, a); send_byte(8'h66, a); b_stop;
    chk("R3 no writes while ignoring", wr_cnt - w0, 0);
    strap_a0 = 1'b0;

    // R4 command refusal causes and the legal boundary
    boot_busy = 1'b1; w0 = wr_cnt;
    b_start; send_byte(addr_byte(1'b0, 1'b0, 1'b0), a);
    chk("R4 address still acked while busy", a, 1);
    send_byte(8'h10, a); chk("R4 boot_busy nack", a, 0);
    send_byte(8'h77, a); b_stop;
    boot_busy = 1'b0; nvm_busy = 1'b1;
    b_start; send_byte(addr_byte(1'b0, 1'b0, 1'b0), a);
    send_byte(8'h10, a); chk("R4 nvm_busy nack", a, 0);
    send_byte(8'h77, a); b_stop;
    nvm_busy = 1'b0;
    b_start; send_byte(addr_byte(1'b0, 1'b0, 1'b0), a);
    send_byte(8'(LAST + 1), a); chk("R4 illegal address nack", a, 0);
    send_byte(8'h77, a); b_stop;
    chk("R4 no writes after refused command", wr_cnt - w0, 0);
    b_start; send_byte(addr_byte(1'b0, 1'b0, 1'b0), a);
    send_byte(8'(LAST), a); chk("R4 last legal address acked", a, 1);
    b_stop;

    // R5 pointer wrap
    buf_d[0] = 8'h11; buf_d[1] = 8'h22; buf_d[2] = 8'h33;
    do_write(1'b0, 8'(LAST - 1), 3, ok);
    chk("R5 wrap acks", ok, 1);
    chk("R5 before wrap", mem[LAST], 8'h22);
    chk("R5 after wrap", mem[0], 8'h33);

    // R6 R7 read with wrap, master NACK, then an extra clocked byte
    r0 = rd_cnt;
    do_read(8'(LAST - 1), 3, 1'b1, ok);
    chk("R6 read acks", ok, 1);
    chk("R6 read byte0", buf_r[0], 8'h11);
    chk("R6 read byte1", buf_r[1], 8'h22);
    chk("R6 read wrapped byte2", buf_r[2], 8'h33);
    chk("R7 read requests stop at NACK", rd_cnt - r0, 3);
    chk("R7 line released after read", sda_oe, 0);

    // R8 mid-byte STOP, then a byte without START
    w0 = wr_cnt;
    b_start; send_byte(addr_byte(1'b0, 1'b0, 1'b0), a); send_byte(8'h20, a);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    b_stop;
    chk("R8 no write from partial byte", wr_cnt - w0, 0);
    chk("R8 memory untouched", mem[8'h20], exp_mem[8'h20]);
    sda_m = 1'b1; scl_m = 1'b0; tick(Q);
    send_byte(addr_byte(1'b0, 1'b0, 1'b0), a);
    chk("R8 idle after STOP ignores byte", a, 0);
    b_stop;

    // R9 STOP inside the START high interval is ignored
    sda_m = 1'b0; tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b0; tick(Q);
    send_byte(addr_byte(1'b0, 1'b0, 1'b0), a);
    chk("R9 address acked after ignored STOP", a, 1);
    send_byte(8'h30, a); send_byte(8'h9A, a); b_stop;
    exp_mem[8'h30] = 8'h9A;
    chk("R9 write completes", mem[8'h30], 8'h9A);

    // R10 one-cycle glitches on SCL and on SDA
    gmode = 1; buf_d[0] = 8'hC3;
    do_write(1'b0, 8'h12, 1, ok);
    chk("R10 SCL glitch acks", ok, 1);
    chk("R10 SCL glitch data", mem[8'h12], 8'hC3);
    gmode = 2; buf_d[0] = 8'hFF;
    do_write(1'b0, 8'h2D, 1, ok);
    gmode = 0;
    chk("R10 SDA glitch acks", ok, 1);
    chk("R10 SDA glitch data", mem[8'h2D], 8'hFF);

    // R12 two write sequences joined by a repeated START
    b_start; send_byte(addr_byte(1'b0, 1'b0, 1'b0), a); send_byte(8'h08, a); send_byte(8'h44, a);
    b_start; send_byte(addr_byte(1'b0, 1'b0, 1'b0), a); send_byte(8'h0A, a);
    chk("R12 second command acked", a, 1);
    send_byte(8'h55, a); send_byte(8'h66, a); b_stop;
    exp_mem[8'h08] = 8'h44; exp_mem[8'h0A] = 8'h55; exp_mem[8'h0B] = 8'h66;
    chk("R12 first sequence", mem[8'h08], 8'h44);
    chk("R12 second sequence", {mem[8'h0A], mem[8'h0B]}, 16'h5566);

    // R5 R6 random write then read-back
    for (int it = 0; it < 12; it++) begin
      c = 8'($urandom % (LAST + 1));
      n = 1 + int'($urandom % 4);
      for (int k = 0; k < n; k++) buf_d[k] = 8'($urandom);
      do_write(1'($urandom), c, n, ok);
      chk("R5 random write acks", ok, 1);
      do_read(c, n, 1'b0, ok);
      chk("R6 random read acks", ok, 1);
      for (int k = 0; k < n; k++) chk("R6 random read data", buf_r[k], buf_d[k]);
    end
    for (int i = 0; i <= LAST; i++) if (mem[i] != exp_mem[i]) chk("R5 memory image", mem[i], exp_mem[i]);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule